// File: doc/BRIEF.md
# Opcode and Operand Staging Stage

This block sits between a byte-granular instruction word queue and the dispatch logic of a microcoded processor. Two byte-wide holding registers take bytes from the queue: the opcode register (J) and the byte after it (H). The opcode is looked up in an external length table. Once enough bytes are present, the decoded entry is moved into a decoded level (M), where it waits for a dispatch. A dispatch moves the entry's operand bytes into an operand level (X). The processor drains that level one byte at a time with an operand-read strobe, and a small counter tracks how many reads the current opcode has made.

Opcodes are one, two or three bytes long. A three-byte opcode keeps its second operand back. That byte enters M only at dispatch and moves to X only after the first operand has been read. Until then, M cannot take the next opcode. A jump-class opcode drops the queue contents and the J/H bytes as it enters M. A flush clears every level.

Top module: `opstage`

## Requirements
- R1: M loads from J only when M is empty (or being dispatched in the same cycle and not held by a three-byte opcode). It also needs one of the following: decoded length 1; length 2 with H valid; or length 3 with H valid and `src_word_any` high. A `dec_len` code of 0 counts as length 1.
- R2: A phase bit is 0 (even) in the first cycle after reset and toggles every cycle. An empty J takes a queue byte only in an even cycle. H takes the byte after the opcode only in an odd cycle: the one after J loaded, or the first odd cycle after that byte becomes available.
- R3: When a length-1 opcode enters M while H holds the next opcode, that byte moves into J in the same cycle. Dispatch requests held high then dispatch consecutive one-byte opcodes in consecutive cycles.
- R4: For a length-3 opcode, the third byte is loaded into H after M loads and is needed before dispatch. It reaches the operand level only on the first operand read after dispatch. Until that read, `disp_rdy` stays low.
- R5: `disp_rdy` is high when M holds an entry whose bytes are complete. `ent_info` then shows that entry's table information. One- and two-byte opcodes may be dispatched before any operand read.
- R6: A dispatch request while `disp_rdy` is low raises `not_rdy` in that cycle and consumes nothing.
- R7: `rd_cnt` counts operand reads since the last dispatch. It clears on dispatch, wins over a read in the same cycle, and saturates at 7.
- R8: An opcode with `dec_jump` high pulses `fifo_drop` as it enters M and leaves J and H empty.
- R9: `flush` empties J, H, M and X and clears `rd_cnt`.
- R10: After reset, `disp_rdy`, `opnd_vld`, `src_take` are 0 and `rd_cnt` is 0.
- R11: After dispatch, `opnd_byte` presents the first operand, and then (for length 3) the second after one read. `opnd_vld` is high only while a not-yet-read operand is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all staging levels |
| src_vld | input | 1 | Queue has a byte available |
| src_byte | input | BYTE_W | Next queue byte |
| src_word_any | input | 1 | At least one queue word level valid |
| src_take | output | 1 | Pop one byte from the queue |
| fifo_drop | output | 1 | Discard queue contents (jump opcode) |
| dec_op | output | BYTE_W | Opcode presented to the length table |
| dec_len | input | 2 | Length from table (1..3, 0 as 1) |
| dec_jump | input | 1 | Opcode is jump or pause class |
| dec_info | input | INFO_W | Entry information from table |
| disp_req | input | 1 | Dispatch request |
| disp_rdy | output | 1 | M holds a dispatchable entry |
| not_rdy | output | 1 | Dispatch requested but not possible |
| ent_info | output | INFO_W | Entry information of the M entry |
| opnd_rd | input | 1 | Operand-read strobe |
| opnd_vld | output | 1 | Operand byte valid |
| opnd_byte | output | BYTE_W | Current operand byte |
| rd_cnt | output | CNT_W | Operand reads since last dispatch |

## Verification
Two functions can coincide. The first pair is a dispatch of the M entry and the reload of M from J on the same edge; the bench provokes it by holding `disp_req` high across three queued one-byte opcodes. The result is judged by `ent_info` changing on each edge while `disp_rdy` never drops. The second pair is a dispatch together with an operand read for the outgoing opcode. It is judged by `rd_cnt` reading 0 and `opnd_byte` showing the new entry's first operand.

// File: rtl/opstage_pkg.sv
package opstage_pkg;

  // Table code 0 is treated as a one-byte opcode.
  function automatic logic [1:0] norm_len(input logic [1:0] raw);
    return (raw == 2'd0) ? 2'd1 : raw;
  endfunction

  // Byte availability needed for an opcode of the given length to enter M.
  function automatic logic bytes_ok(input logic [1:0] len, input logic h_ok,
                                    input logic word_ok);
    case (len)
      2'd2:    return h_ok;
      2'd3:    return h_ok && word_ok;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/opstage_jh.sv
module opstage_jh #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              src_vld,
  input  logic [BYTE_W-1:0] src_byte,
  input  logic              m_ld,
  input  logic [1:0]        m_ld_len,
  input  logic              m_ld_jump,
  input  logic              b_take,
  output logic              j_vld,
  output logic              j_bwait,
  output logic              h_vld,
  output logic [BYTE_W-1:0] j_byte,
  output logic [BYTE_W-1:0] h_byte,
  output logic              src_take,
  output logic              j_ld_ev,
  output logic              h_ld_ev,
  output logic              phase
);

  assign j_ld_ev  = !phase && !j_vld && !j_bwait && src_vld && !flush;
  assign h_ld_ev  = phase && !h_vld && ((j_vld && !m_ld) || j_bwait) && src_vld && !flush;
  assign src_take = j_ld_ev || h_ld_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      j_vld   <= 1'b0;
      h_vld   <= 1'b0;
      j_bwait <= 1'b0;
      j_byte  <= '0;
      h_byte  <= '0;
    end else begin
      phase <= ~phase;
      if (flush || (m_ld && m_ld_jump)) begin
        j_vld   <= 1'b0;
        h_vld   <= 1'b0;
        j_bwait <= 1'b0;
      end else begin
        if (j_ld_ev) begin
          j_vld  <= 1'b1;
          j_byte <= src_byte;
        end
        if (h_ld_ev) begin
          h_vld  <= 1'b1;
          h_byte <= src_byte;
        end
        if (m_ld) begin
          case (m_ld_len)
            2'd2: begin
              j_vld <= 1'b0;
              h_vld <= 1'b0;
            end
            2'd3: begin
              j_vld   <= 1'b0;
              h_vld   <= 1'b0;
              j_bwait <= 1'b1;
            end
            default: begin
              if (h_vld) begin
                j_byte <= h_byte;
                h_vld  <= 1'b0;
              end else begin
                j_vld <= 1'b0;
              end
            end
          endcase
        end
        if (b_take) begin
          h_vld   <= 1'b0;
          j_bwait <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/opstage_m.sv
module opstage_m #(
  parameter int BYTE_W = 8,
  parameter int INFO_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              j_vld,
  input  logic              j_bwait,
  input  logic              h_vld,
  input  logic [BYTE_W-1:0] h_byte,
  input  logic              word_any,
  input  logic [1:0]        len_n,
  input  logic [INFO_W-1:0] dec_info,
  input  logic              dec_jump,
  input  logic              disp_req,
  input  logic              b_pop,
  output logic              m_ld,
  output logic [1:0]        m_len,
  output logic [BYTE_W-1:0] m_a,
  output logic [INFO_W-1:0] m_info,
  output logic              mb_vld,
  output logic [BYTE_W-1:0] mb_byte,
  output logic              disp_rdy,
  output logic              disp_ok,
  output logic              b_take
);
  import opstage_pkg::*;

  logic m_vld;
  logic m_jump;
  logic m_free;
  logic need_b;

  assign need_b   = (m_len == 2'd3) && !m_jump;
  assign disp_rdy = m_vld && (!need_b || (j_bwait && h_vld));
  assign disp_ok  = disp_req && disp_rdy && !flush;
  assign b_take   = disp_ok && need_b;
  assign m_free   = (!m_vld && !mb_vld) || (disp_ok && !b_take);
  assign m_ld     = j_vld && m_free && bytes_ok(len_n, h_vld, word_any) && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_vld   <= 1'b0;
      m_jump  <= 1'b0;
      m_len   <= 2'd1;
      m_a     <= '0;
      m_info  <= '0;
      mb_vld  <= 1'b0;
      mb_byte <= '0;
    end else if (flush) begin
      m_vld  <= 1'b0;
      mb_vld <= 1'b0;
    end else begin
      if (m_ld) begin
        m_vld  <= 1'b1;
        m_jump <= dec_jump;
        m_len  <= len_n;
        m_a    <= h_byte;
        m_info <= dec_info;
      end else if (disp_ok) begin
        m_vld <= 1'b0;
      end
      if (b_take) begin
        mb_vld  <= 1'b1;
        mb_byte <= h_byte;
      end else if (b_pop) begin
        mb_vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/opstage_x.sv
module opstage_x #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              disp_ok,
  input  logic [1:0]        m_len,
  input  logic [BYTE_W-1:0] m_a,
  input  logic              b_take,
  input  logic [BYTE_W-1:0] mb_byte,
  input  logic              opnd_rd,
  output logic              b_pop,
  output logic              opnd_vld,
  output logic [BYTE_W-1:0] opnd_byte,
  output logic [CNT_W-1:0]  rd_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic [BYTE_W-1:0] x_a;
  logic [BYTE_W-1:0] x_b;
  logic              has_a;
  logic              has_b;
  logic              x_bwait;
  logic [1:0]        pos;

  assign b_pop     = opnd_rd && x_bwait && !disp_ok && !flush;
  assign opnd_vld  = (pos == 2'd0) ? has_a : ((pos == 2'd1) ? has_b : 1'b0);
  assign opnd_byte = (pos == 2'd0) ? x_a : x_b;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      x_a     <= '0;
      x_b     <= '0;
      has_a   <= 1'b0;
      has_b   <= 1'b0;
      x_bwait <= 1'b0;
      pos     <= 2'd0;
      rd_cnt  <= '0;
    end else if (disp_ok) begin
      x_a     <= m_a;
      has_a   <= (m_len != 2'd1);
      has_b   <= 1'b0;
      x_bwait <= b_take;
      pos     <= 2'd0;
      rd_cnt  <= '0;
    end else if (opnd_rd) begin
      rd_cnt <= sat_inc(rd_cnt);
      if (pos != 2'd2) pos <= pos + 2'd1;
      if (x_bwait) begin
        x_b     <= mb_byte;
        has_b   <= 1'b1;
        x_bwait <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/opstage.sv
module opstage #(
  parameter int BYTE_W = 8,
  parameter int INFO_W = 10,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              src_vld,
  input  logic [BYTE_W-1:0] src_byte,
  input  logic              src_word_any,
  output logic              src_take,
  output logic              fifo_drop,
  output logic [BYTE_W-1:0] dec_op,
  input  logic [1:0]        dec_len,
  input  logic              dec_jump,
  input  logic [INFO_W-1:0] dec_info,
  input  logic              disp_req,
  output logic              disp_rdy,
  output logic              not_rdy,
  output logic [INFO_W-1:0] ent_info,
  input  logic              opnd_rd,
  output logic              opnd_vld,
  output logic [BYTE_W-1:0] opnd_byte,
  output logic [CNT_W-1:0]  rd_cnt
);
  import opstage_pkg::*;

  logic              j_vld, j_bwait, h_vld, j_ld_ev, h_ld_ev, phase;
  logic [BYTE_W-1:0] j_byte, h_byte, m_a, mb_byte;
  logic              m_ld, mb_vld, disp_ok, b_take, b_pop;
  logic [1:0]        m_len, len_n;

  assign len_n     = norm_len(dec_len);
  assign dec_op    = j_byte;
  assign fifo_drop = m_ld && dec_jump;
  assign not_rdy   = disp_req && !disp_ok;

  opstage_jh #(.BYTE_W(BYTE_W)) u_jh (
    .clk(clk), .rst_n(rst_n), .flush(flush), .src_vld(src_vld), .src_byte(src_byte),
    .m_ld(m_ld), .m_ld_len(len_n), .m_ld_jump(dec_jump), .b_take(b_take),
    .j_vld(j_vld), .j_bwait(j_bwait), .h_vld(h_vld), .j_byte(j_byte), .h_byte(h_byte),
    .src_take(src_take), .j_ld_ev(j_ld_ev), .h_ld_ev(h_ld_ev), .phase(phase)
  );

  opstage_m #(.BYTE_W(BYTE_W), .INFO_W(INFO_W)) u_m (
    .clk(clk), .rst_n(rst_n), .flush(flush), .j_vld(j_vld), .j_bwait(j_bwait),
    .h_vld(h_vld), .h_byte(h_byte), .word_any(src_word_any), .len_n(len_n),
    .dec_info(dec_info), .dec_jump(dec_jump), .disp_req(disp_req), .b_pop(b_pop),
    .m_ld(m_ld), .m_len(m_len), .m_a(m_a), .m_info(ent_info), .mb_vld(mb_vld),
    .mb_byte(mb_byte), .disp_rdy(disp_rdy), .disp_ok(disp_ok), .b_take(b_take)
  );

  opstage_x #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_x (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_ok(disp_ok), .m_len(m_len),
    .m_a(m_a), .b_take(b_take), .mb_byte(mb_byte), .opnd_rd(opnd_rd),
    .b_pop(b_pop), .opnd_vld(opnd_vld), .opnd_byte(opnd_byte), .rd_cnt(rd_cnt)
  );

endmodule

// File: rtl/opstage_chk.sv
module opstage_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             phase,
  input logic             j_ld_ev,
  input logic             h_ld_ev,
  input logic             m_ld,
  input logic [1:0]       len_n,
  input logic             h_vld,
  input logic             j_vld,
  input logic             src_word_any,
  input logic             not_rdy,
  input logic             opnd_rd,
  input logic [CNT_W-1:0] rd_cnt,
  input logic             disp_ok,
  input logic             disp_rdy,
  input logic             opnd_vld,
  input logic             fifo_drop,
  input logic             mb_vld
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_J_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    j_ld_ev |-> !phase); // R2
  AST_H_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    h_ld_ev |-> phase); // R2
  AST_LEN2_NEEDS_H: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ld && len_n == 2'd2) |-> h_vld); // R1
  AST_LEN3_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ld && len_n == 2'd3) |-> (h_vld && src_word_any)); // R1
  AST_B_BLOCKS_M: assert property (@(posedge clk) disable iff (!rst_n)
    mb_vld |-> !disp_rdy); // R4
  AST_NOTRDY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (not_rdy && !opnd_rd && !flush) |=> $stable(rd_cnt)); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ok |=> (rd_cnt == '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt == CMAX && opnd_rd && !disp_ok && !flush) |=> (rd_cnt == CMAX)); // R7
  AST_JUMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> (!j_vld && !h_vld)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!disp_rdy && !opnd_vld && rd_cnt == '0)); // R9

endmodule

bind opstage opstage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .phase(phase), .j_ld_ev(j_ld_ev),
  .h_ld_ev(h_ld_ev), .m_ld(m_ld), .len_n(len_n), .h_vld(h_vld), .j_vld(j_vld),
  .src_word_any(src_word_any), .not_rdy(not_rdy), .opnd_rd(opnd_rd), .rd_cnt(rd_cnt),
  .disp_ok(disp_ok), .disp_rdy(disp_rdy), .opnd_vld(opnd_vld), .fifo_drop(fifo_drop),
  .mb_vld(mb_vld)
);

// File: tb/sim_opstage.sv
module sim_opstage;
  localparam int CLK_PERIOD = 10;
  localparam int BYTE_W = 8;
  localparam int INFO_W = 10;
  localparam int CNT_W  = 3;
  localparam int NVEC   = 6;
  // each vector: opcode, first operand, second operand
  localparam logic [23:0] VEC [NVEC] = '{
    24'h01_00_00, 24'h02_A5_00, 24'h03_3C_C3,
    24'h0D_00_00, 24'h16_77_00, 24'h4B_12_34
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic src_vld, src_word_any, src_take, fifo_drop;
  logic [BYTE_W-1:0] src_byte, dec_op, opnd_byte;
  logic [1:0] dec_len;
  logic dec_jump;
  logic [INFO_W-1:0] dec_info, ent_info;
  logic disp_req = 1'b0;
  logic opnd_rd = 1'b0;
  logic disp_rdy, not_rdy, opnd_vld;
  logic [CNT_W-1:0] rd_cnt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic hold_word = 1'b0;
  logic [7:0] qmem [64];
  int wr = 0;
  int rd = 0;
  int cyc = 0;
  int drops = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign src_vld      = (rd != wr);
  assign src_byte     = qmem[rd % 64];
  assign src_word_any = src_vld && !hold_word;

  function automatic logic [1:0] ref_len(input logic [7:0] op);
    return (op[1:0] == 2'd0) ? 2'd1 : op[1:0];
  endfunction
  function automatic logic [INFO_W-1:0] ref_info(input logic [7:0] op);
    return {2'b10, op};
  endfunction

  always_comb begin
    dec_len  = dec_op[1:0];
    dec_jump = dec_op[7];
    dec_info = ref_info(dec_op);
  end

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
    if (flush || fifo_drop) rd <= wr;
    else if (src_take) rd <= rd + 1;
    if (fifo_drop) drops <= drops + 1;
  end

  opstage #(.BYTE_W(BYTE_W), .INFO_W(INFO_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .src_vld(src_vld), .src_byte(src_byte),
    .src_word_any(src_word_any), .src_take(src_take), .fifo_drop(fifo_drop),
    .dec_op(dec_op), .dec_len(dec_len), .dec_jump(dec_jump), .dec_info(dec_info),
    .disp_req(disp_req), .disp_rdy(disp_rdy), .not_rdy(not_rdy), .ent_info(ent_info),
    .opnd_rd(opnd_rd), .opnd_vld(opnd_vld), .opnd_byte(opnd_byte), .rd_cnt(rd_cnt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    qmem[wr % 64] = b;
    wr = wr + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rdy(output bit got);
    got = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (disp_rdy) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic wait_take(output bit par, output bit got);
    got = 1'b0;
    par = 1'b0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (src_take) begin
        par = cyc[0];
        got = 1'b1;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic dispatch();
    disp_req = 1'b1;
    @(negedge clk);
    disp_req = 1'b0;
  endtask

  task automatic read_op();
    opnd_rd = 1'b1;
    @(negedge clk);
    opnd_rd = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit got, par;
    logic [7:0] op, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!disp_rdy && !opnd_vld && !src_take, "R10 idle flags", {disp_rdy, opnd_vld, src_take}, 0);
    chk(rd_cnt == 0, "R10 count", rd_cnt, 0);

    // R6 dispatch on empty M
    disp_req = 1'b1;
    #1;
    chk(not_rdy == 1'b1, "R6 not_rdy", not_rdy, 1);
    @(negedge clk);
    disp_req = 1'b0;
    chk(rd_cnt == 0 && !disp_rdy, "R6 nothing consumed", rd_cnt, 0);

    // vector table: main function over lengths 1..3
    for (int v = 0; v < NVEC; v++) begin
      op = VEC[v][23:16]; a = VEC[v][15:8]; b = VEC[v][7:0];
      push(op);
      if (ref_len(op) >= 2) push(a);
      if (ref_len(op) == 3) push(b);
      wait_rdy(got);
      chk(got, "R5 ready", got, 1);
      chk(ent_info == ref_info(op), "R5 entry info", ent_info, ref_info(op));
      dispatch();
      chk(rd_cnt == 0, "R7 cleared by dispatch", rd_cnt, 0);
      if (ref_len(op) >= 2) begin
        chk(opnd_vld && opnd_byte == a, "R11 first operand", opnd_byte, a);
        read_op();
        if (ref_len(op) == 3) begin
          chk(opnd_vld && opnd_byte == b, "R4 second operand", opnd_byte, b);
          read_op();
        end
        chk(!opnd_vld, "R11 operands drained", opnd_vld, 0);
        chk(rd_cnt == {1'b0, ref_len(op)} - 3'd1, "R7 read count", rd_cnt, ref_len(op) - 1);
      end else begin
        chk(!opnd_vld, "R11 no operand len1", opnd_vld, 0);
      end
    end
    idle(2);

    // R2 phase of J and H loads, late operand byte
    push(8'h02);
    wait_take(par, got);
    chk(got && par == 1'b0, "R2 J load even", par, 0);
    idle(3);
    chk(!disp_rdy, "R1 len2 waits for H", disp_rdy, 0);
    push(8'h99);
    wait_take(par, got);
    chk(got && par == 1'b1, "R2 H load odd", par, 1);
    wait_rdy(got);
    dispatch();
    read_op();

    // R1 three-byte opcode gated by queue word level
    hold_word = 1'b1;
    push(8'h07); push(8'h51); push(8'h52);
    idle(10);
    chk(!disp_rdy, "R1 len3 waits for word", disp_rdy, 0);
    hold_word = 1'b0;
    wait_rdy(got);
    chk(got && ent_info == ref_info(8'h07), "R1 len3 loaded", ent_info, ref_info(8'h07));

    // R4 next opcode held until first operand read
    push(8'h05);
    dispatch();
    idle(6);
    chk(!disp_rdy, "R4 M held by third byte", disp_rdy, 0);
    disp_req = 1'b1;
    #1;
    chk(not_rdy, "R4 early dispatch refused", not_rdy, 1);
    @(negedge clk);
    disp_req = 1'b0;
    chk(opnd_byte == 8'h51, "R4 first operand kept", opnd_byte, 8'h51);
    read_op();
    chk(opnd_vld && opnd_byte == 8'h52, "R4 third byte after read", opnd_byte, 8'h52);
    wait_rdy(got);
    chk(got && ent_info == ref_info(8'h05), "R4 next opcode after read", ent_info, ref_info(8'h05));

    // R3 back-to-back one-byte dispatches with H->J transfer
    push(8'h09); push(8'h0D);
    idle(6);
    chk(disp_rdy && ent_info == ref_info(8'h05), "R3 first entry", ent_info, ref_info(8'h05));
    disp_req = 1'b1;
    @(negedge clk);
    chk(disp_rdy && ent_info == ref_info(8'h09), "R3 second entry", ent_info, ref_info(8'h09));
    @(negedge clk);
    chk(disp_rdy && ent_info == ref_info(8'h0D), "R3 third entry", ent_info, ref_info(8'h0D));
    @(negedge clk);
    disp_req = 1'b0;
    chk(!disp_rdy, "R3 pipe drained", disp_rdy, 0);

    // R8 jump opcode discards following bytes
    drops = 0;
    push(8'h81); push(8'h02); push(8'h03);
    wait_rdy(got);
    chk(drops == 1, "R8 drop pulse", drops, 1);
    dispatch();
    idle(8);
    chk(!disp_rdy && rd == wr, "R8 nothing after jump", disp_rdy, 0);

    // R7 saturation
    push(8'h02); push(8'hAA);
    wait_rdy(got);
    dispatch();
    for (int i = 0; i < 9; i++) read_op();
    chk(rd_cnt == 3'd7, "R7 saturate", rd_cnt, 7);

    // R7/R11 dispatch and read in the same cycle
    push(8'h22); push(8'hCC);
    wait_rdy(got);
    disp_req = 1'b1;
    opnd_rd = 1'b1;
    @(negedge clk);
    disp_req = 1'b0;
    opnd_rd = 1'b0;
    chk(rd_cnt == 0, "R7 dispatch beats read", rd_cnt, 0);
    chk(opnd_vld && opnd_byte == 8'hCC, "R11 new operand", opnd_byte, 8'hCC);
    read_op();
    push(8'h01);
    wait_rdy(got);

    // R9 flush
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(!disp_rdy && !opnd_vld, "R9 levels empty", {disp_rdy, opnd_vld}, 0);
    chk(rd_cnt == 0, "R9 count cleared", rd_cnt, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule